// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for a parallel RGB panel. From the system clock it derives a pixel-rate strobe, either by division or by using every system cycle, and uses it to run a horizontal and a vertical position counter. From their positions it drives horizontal sync, vertical sync, data enable and the column and row of the current active pixel. Pixel fetch and colour handling sit downstream. They use `pix_ce` and the registered outputs to know when, and for which pixel, to present data.

The geometry comes in through plain configuration inputs in an offset-encoded form. Sync widths, the horizontal porches, the vertical front porch and both active sizes are stored as the count minus one. The vertical back porch is stored as the plain line count, so it may be zero. The divider field holds the divisor minus two. Each sync output has its own polarity select, and the pixel strobe output `pclk_o` can be inverted. Configuration may only change while `run_en` is low.

Top module: `lcd_raster_top`

## Requirements
- R1: With `cfg_clk_bypass`=0, `pix_ce` is high for one cycle in every `cfg_clk_div`+2 system cycles. The first pulse comes `cfg_clk_div`+2 cycles after the first cycle with `run_en` high.
- R2: With `cfg_clk_bypass`=1, `pix_ce` is high in every cycle from the second cycle of a run onward.
- R3: A line has (`cfg_hsw`+1)+(`cfg_hbp`+1)+(`cfg_hact`+1)+(`cfg_hfp`+1) pixels, in the order sync, back porch, active, front porch. Horizontal sync is active for the first `cfg_hsw`+1 pixels.
- R4: A frame has (`cfg_vsw`+1)+`cfg_vbp`+(`cfg_vact`+1)+(`cfg_vfp`+1) lines. The back porch count has no offset, so 0 gives no back porch lines.
- R5: Vertical sync is active for the first `cfg_vsw`+1 lines. It changes only together with the first pixel of a line, which is the start of the horizontal sync pulse.
- R6: `de_o` is high only when both positions are in their active regions. `col_o` and `row_o` then give the index within the active region (0..`cfg_hact`, 0..`cfg_vact`), and they are 0 whenever `de_o` is low.
- R7: When `cfg_hs_pol` is 1 the horizontal sync pulse is active low, otherwise active high. `cfg_vs_pol` acts the same way on vertical sync. The inactive level equals the polarity bit.
- R8: `pclk_o` XOR `cfg_pclk_inv` is 1 exactly in the cycles in which the timing outputs take a new pixel's values, and 0 otherwise.
- R9: While `run_en` is low, all counters hold zero, `pix_ce`, `de_o`, `col_o` and `row_o` are 0, and each sync output sits at its inactive level. When `run_en` rises, timing restarts at pixel 0 of line 0.
- R10: Synchronous reset puts the outputs in the same idle state as R9. All timing outputs are registered and show the position counter value of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable; low holds the raster idle |
| cfg_clk_bypass | input | 1 | 1: system clock rate is the pixel rate |
| cfg_clk_div | input | DIV_W | Pixel divisor minus two |
| cfg_pclk_inv | input | 1 | Inverts `pclk_o` |
| cfg_hs_pol | input | 1 | 1: horizontal sync active low |
| cfg_vs_pol | input | 1 | 1: vertical sync active low |
| cfg_hsw | input | H_W | Horizontal sync width minus one |
| cfg_hbp | input | H_W | Horizontal back porch minus one |
| cfg_hact | input | H_W | Active pixels per line minus one |
| cfg_hfp | input | H_W | Horizontal front porch minus one |
| cfg_vsw | input | V_W | Vertical sync width minus one |
| cfg_vbp | input | V_W | Vertical back porch, plain count |
| cfg_vact | input | V_W | Active lines minus one |
| cfg_vfp | input | V_W | Vertical front porch minus one |
| pix_ce | output | 1 | Pixel-rate strobe |
| pclk_o | output | 1 | Pixel update marker, polarity selectable |
| hs_o | output | 1 | Horizontal sync |
| vs_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| col_o | output | H_W | Active column index |
| row_o | output | V_W | Active row index |

## Verification
A small table of geometries is run. It covers a divided pixel rate with divisors 2, 3 and 5, the bypassed rate, zero and non-zero vertical back porch, a single-pixel and single-line active area, and every polarity combination. A reference model in the bench follows each pixel strobe and compares every output in every cycle. Because of this, an off-by-one in any single offset decode shows up as a shifted sync, enable or index. Directed runs then drop `run_en` in the middle of a frame and apply reset during a run, to show that both paths return to the idle state and restart at pixel 0 of line 0.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;
  // region of a raster axis, in scan order
  typedef enum logic [1:0] {
    SEG_SYNC  = 2'd0,
    SEG_BACK  = 2'd1,
    SEG_ACT   = 2'd2,
    SEG_FRONT = 2'd3
  } seg_e;
endpackage

// File: rtl/raster_clk_div.sv
module raster_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             bypass,
  input  logic [DIV_W-1:0] div_m2,
  output logic             tick
);
  localparam int PW = DIV_W + 1;

  logic [PW-1:0] ph;
  logic [PW-1:0] ph_last;
  logic          wrap;

  // divisor minus one is the last phase
  assign ph_last = PW'(div_m2) + PW'(1);
  assign wrap    = bypass || (ph == ph_last);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ph   <= '0;
      tick <= 1'b0;
    end else begin
      tick <= wrap;
      ph   <= wrap ? '0 : ph + PW'(1);
    end
  end
endmodule

// File: rtl/raster_axis.sv
module raster_axis
  import lcd_raster_pkg::*;
#(
  parameter int W      = 11,
  parameter bit BP_RAW = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] sync_m1,
  input  logic [W-1:0] back_f,
  input  logic [W-1:0] act_m1,
  input  logic [W-1:0] front_m1,
  output seg_e         seg,
  output logic [W-1:0] idx,
  output logic         carry
);
  localparam int CW = W + 3;

  logic [CW-1:0] cnt;
  logic [CW-1:0] back_n;
  logic [CW-1:0] sync_end, act_beg, act_end, total_m1;

  // back porch decode differs between axes
  generate
    if (BP_RAW) begin : g_bp_raw
      assign back_n = CW'(back_f);
    end else begin : g_bp_m1
      assign back_n = CW'(back_f) + CW'(1);
    end
  endgenerate

  assign sync_end = CW'(sync_m1) + CW'(1);
  assign act_beg  = sync_end + back_n;
  assign act_end  = act_beg + CW'(act_m1) + CW'(1);
  assign total_m1 = act_end + CW'(front_m1);

  always_comb begin
    if (cnt < sync_end)     seg = SEG_SYNC;
    else if (cnt < act_beg) seg = SEG_BACK;
    else if (cnt < act_end) seg = SEG_ACT;
    else                    seg = SEG_FRONT;
  end

  assign idx   = (seg == SEG_ACT) ? W'(cnt - act_beg) : '0;
  assign carry = step && (cnt == total_m1);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (carry)  cnt <= '0;
    else if (step)   cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/lcd_raster_top.sv
module lcd_raster_top
  import lcd_raster_pkg::*;
#(
  parameter int H_W   = 11,
  parameter int V_W   = 11,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             cfg_clk_bypass,
  input  logic [DIV_W-1:0] cfg_clk_div,
  input  logic             cfg_pclk_inv,
  input  logic             cfg_hs_pol,
  input  logic             cfg_vs_pol,
  input  logic [H_W-1:0]   cfg_hsw,
  input  logic [H_W-1:0]   cfg_hbp,
  input  logic [H_W-1:0]   cfg_hact,
  input  logic [H_W-1:0]   cfg_hfp,
  input  logic [V_W-1:0]   cfg_vsw,
  input  logic [V_W-1:0]   cfg_vbp,
  input  logic [V_W-1:0]   cfg_vact,
  input  logic [V_W-1:0]   cfg_vfp,
  output logic             pix_ce,
  output logic             pclk_o,
  output logic             hs_o,
  output logic             vs_o,
  output logic             de_o,
  output logic [H_W-1:0]   col_o,
  output logic [V_W-1:0]   row_o
);
  logic           tick;
  logic           tick_d;
  logic           h_carry;
  logic           unused_v_carry;
  seg_e           h_seg, v_seg;
  logic [H_W-1:0] h_idx;
  logic [V_W-1:0] v_idx;
  logic           in_act;

  raster_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .run    (run_en),
    .bypass (cfg_clk_bypass),
    .div_m2 (cfg_clk_div),
    .tick   (tick)
  );

  raster_axis #(.W(H_W), .BP_RAW(1'b0)) u_h (
    .clk      (clk),
    .rst      (rst),
    .clr      (!run_en),
    .step     (tick),
    .sync_m1  (cfg_hsw),
    .back_f   (cfg_hbp),
    .act_m1   (cfg_hact),
    .front_m1 (cfg_hfp),
    .seg      (h_seg),
    .idx      (h_idx),
    .carry    (h_carry)
  );

  raster_axis #(.W(V_W), .BP_RAW(1'b1)) u_v (
    .clk      (clk),
    .rst      (rst),
    .clr      (!run_en),
    .step     (h_carry),
    .sync_m1  (cfg_vsw),
    .back_f   (cfg_vbp),
    .act_m1   (cfg_vact),
    .front_m1 (cfg_vfp),
    .seg      (v_seg),
    .idx      (v_idx),
    .carry    (unused_v_carry)
  );

  assign pix_ce = tick;
  assign in_act = (h_seg == SEG_ACT) && (v_seg == SEG_ACT);

  // output stage: one register after the position counters
  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      tick_d <= 1'b0;
      pclk_o <= cfg_pclk_inv;
      hs_o   <= cfg_hs_pol;
      vs_o   <= cfg_vs_pol;
      de_o   <= 1'b0;
      col_o  <= '0;
      row_o  <= '0;
    end else begin
      tick_d <= tick;
      pclk_o <= tick_d ^ cfg_pclk_inv;
      hs_o   <= (h_seg == SEG_SYNC) ^ cfg_hs_pol;
      vs_o   <= (v_seg == SEG_SYNC) ^ cfg_vs_pol;
      de_o   <= in_act;
      col_o  <= in_act ? h_idx : '0;
      row_o  <= in_act ? v_idx : '0;
    end
  end
endmodule

// File: rtl/lcd_raster_chk.sv
module lcd_raster_chk #(
  parameter int H_W = 11,
  parameter int V_W = 11
) (
  input logic           clk,
  input logic           rst,
  input logic           run_en,
  input logic           cfg_clk_bypass,
  input logic           cfg_hs_pol,
  input logic           cfg_vs_pol,
  input logic [H_W-1:0] cfg_hact,
  input logic [V_W-1:0] cfg_vact,
  input logic           pix_ce,
  input logic           hs_o,
  input logic           vs_o,
  input logic           de_o,
  input logic [H_W-1:0] col_o,
  input logic [V_W-1:0] row_o
);
  // R1
  ce_single_chk: assert property (@(posedge clk) disable iff (rst)
    run_en && !cfg_clk_bypass && pix_ce |=> !pix_ce);

  // R2
  ce_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    run_en && cfg_clk_bypass |=> pix_ce);

  // R6
  idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    de_o |-> (col_o <= cfg_hact) && (row_o <= cfg_vact));

  // R6
  idx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !de_o |-> (col_o == '0) && (row_o == '0));

  // R7
  sync_off_in_act_chk: assert property (@(posedge clk) disable iff (rst)
    de_o |-> (hs_o == cfg_hs_pol) && (vs_o == cfg_vs_pol));

  // R9
  halt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !pix_ce && !de_o && (col_o == '0) && (row_o == '0));
endmodule

bind lcd_raster_top lcd_raster_chk #(.H_W(H_W), .V_W(V_W)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .run_en         (run_en),
  .cfg_clk_bypass (cfg_clk_bypass),
  .cfg_hs_pol     (cfg_hs_pol),
  .cfg_vs_pol     (cfg_vs_pol),
  .cfg_hact       (cfg_hact),
  .cfg_vact       (cfg_vact),
  .pix_ce         (pix_ce),
  .hs_o           (hs_o),
  .vs_o           (vs_o),
  .de_o           (de_o),
  .col_o          (col_o),
  .row_o          (row_o)
);

// File: tb/lcd_raster_top_tb.sv
module lcd_raster_top_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        byp;
    logic [7:0]  div;
    logic [10:0] hsw, hbp, hact, hfp;
    logic [10:0] vsw, vbp, vact, vfp;
    logic        hpol, vpol, inv;
    int unsigned cyc;
  } vec_t;

  // byp div | hsw hbp hact hfp | vsw vbp vact vfp | hpol vpol inv | cycles
  localparam vec_t TBL [4] = '{
    '{1'b0, 8'd0, 11'd1, 11'd1, 11'd3, 11'd1, 11'd0, 11'd1, 11'd2, 11'd0, 1'b0, 1'b0, 1'b0, 300},
    '{1'b1, 8'd0, 11'd0, 11'd0, 11'd4, 11'd2, 11'd1, 11'd0, 11'd1, 11'd1, 1'b1, 1'b1, 1'b1, 200},
    '{1'b0, 8'd3, 11'd2, 11'd0, 11'd1, 11'd0, 11'd0, 11'd2, 11'd1, 11'd1, 1'b1, 1'b0, 1'b0, 600},
    '{1'b0, 8'd1, 11'd0, 11'd2, 11'd0, 11'd0, 11'd2, 11'd0, 11'd0, 11'd0, 1'b0, 1'b1, 1'b1, 250}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0;
  vec_t cur = TBL[0];
  vec_t pc  = TBL[0];

  logic        pix_ce, pclk_o, hs_o, vs_o, de_o;
  logic [10:0] col_o, row_o;

  int total = 0;
  int bad = 0;
  bit chk_en = 1'b0;

  // reference model state
  int mh = 0, mv = 0, ph_h = 0, ph_v = 0, g = 1;
  bit pr = 1'b0, pr2 = 1'b0, ce1 = 1'b0, ce2 = 1'b0;
  int hs_n, ha0, ha1, vs_n, va0, va1, ht, vt, dv;
  bit e_hs, e_vs, e_de, e_pclk, eff;
  int e_col, e_row;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_raster_top #(.H_W(11), .V_W(11), .DIV_W(8)) dut_i (
    .clk(clk), .rst(rst), .run_en(run_en),
    .cfg_clk_bypass(cur.byp), .cfg_clk_div(cur.div), .cfg_pclk_inv(cur.inv),
    .cfg_hs_pol(cur.hpol), .cfg_vs_pol(cur.vpol),
    .cfg_hsw(cur.hsw), .cfg_hbp(cur.hbp), .cfg_hact(cur.hact), .cfg_hfp(cur.hfp),
    .cfg_vsw(cur.vsw), .cfg_vbp(cur.vbp), .cfg_vact(cur.vact), .cfg_vfp(cur.vfp),
    .pix_ce(pix_ce), .pclk_o(pclk_o), .hs_o(hs_o), .vs_o(vs_o), .de_o(de_o),
    .col_o(col_o), .row_o(row_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    hs_n = int'(pc.hsw) + 1;
    ha0  = hs_n + int'(pc.hbp) + 1;
    ha1  = ha0 + int'(pc.hact) + 1;
    vs_n = int'(pc.vsw) + 1;
    va0  = vs_n + int'(pc.vbp);
    va1  = va0 + int'(pc.vact) + 1;
    if (pr) begin
      e_hs  = (ph_h < hs_n) ^ pc.hpol;
      e_vs  = (ph_v < vs_n) ^ pc.vpol;
      e_de  = (ph_h >= ha0) && (ph_h < ha1) && (ph_v >= va0) && (ph_v < va1);
      e_col = e_de ? ph_h - ha0 : 0;
      e_row = e_de ? ph_v - va0 : 0;
    end else begin
      e_hs = pc.hpol; e_vs = pc.vpol; e_de = 1'b0; e_col = 0; e_row = 0;
    end
    e_pclk = (pr && pr2 && ce2) ^ pc.inv;
    dv = cur.byp ? 1 : int'(cur.div) + 2;
    if (chk_en) begin
      chk(hs_o === e_hs, !pr ? "R9" : (pc.hpol ? "R7" : "R3"), "hsync", hs_o, e_hs);
      chk(vs_o === e_vs, !pr ? "R9" : (pc.vpol ? "R7" : "R5"), "vsync", vs_o, e_vs);
      chk(de_o === e_de, "R6", "de", de_o, e_de);
      chk(col_o === 11'(e_col), "R3", "col", col_o, e_col);
      chk(row_o === 11'(e_row), "R4", "row", row_o, e_row);
      chk(pclk_o === e_pclk, "R8", "pclk", pclk_o, e_pclk);
      if (!pr) chk(pix_ce === 1'b0, "R9", "pix_ce idle", pix_ce, 0);
      else if (pix_ce) chk(g == dv, cur.byp ? "R2" : "R1", "ce spacing", g, dv);
      else chk(g < dv, cur.byp ? "R2" : "R1", "ce missing", g, dv);
    end
    if (!pr) g = 1;
    else if (pix_ce) g = 1;
    else g++;
    // advance model to the next cycle
    eff = run_en && !rst;
    ht = int'(cur.hsw) + int'(cur.hbp) + int'(cur.hact) + int'(cur.hfp) + 4;
    vt = int'(cur.vsw) + int'(cur.vbp) + int'(cur.vact) + int'(cur.vfp) + 3;
    pc = cur;
    ce2 = ce1; ce1 = pix_ce;
    pr2 = pr;  pr = eff;
    ph_h = mh; ph_v = mv;
    if (!eff) begin
      mh = 0; mv = 0;
    end else if (pix_ce) begin
      if (mh == ht - 1) begin
        mh = 0;
        mv = (mv == vt - 1) ? 0 : mv + 1;
      end else mh++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_en = 1'b1;
    // R10 reset state
    chk(hs_o === cur.hpol && vs_o === cur.vpol && de_o === 1'b0 && pix_ce === 1'b0,
        "R10", "reset idle", {hs_o, vs_o, de_o, pix_ce}, {cur.hpol, cur.vpol, 2'b00});
    @(posedge clk); #1 rst = 1'b0;

    // table walk
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1 run_en = 1'b0;
      repeat (3) @(posedge clk);
      #1 cur = TBL[i];
      repeat (3) @(posedge clk);
      #1 run_en = 1'b1;
      repeat (int'(TBL[i].cyc)) @(posedge clk);
    end

    // R9: stop mid-frame, restart at pixel 0 of line 0
    #1 run_en = 1'b0;
    repeat (3) @(posedge clk);
    #1 cur = TBL[0];
    repeat (3) @(posedge clk);
    #1 run_en = 1'b1;
    repeat (37) @(posedge clk);
    #1 run_en = 1'b0;
    repeat (4) @(posedge clk);
    #1 run_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(hs_o === 1'b1 && vs_o === 1'b1 && de_o === 1'b0, "R9", "restart in sync",
        {hs_o, vs_o, de_o}, 3'b110);
    repeat (150) @(posedge clk);

    // R10: reset during a run
    #1 rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(hs_o === 1'b0 && de_o === 1'b0 && pix_ce === 1'b0 && col_o === 11'd0,
        "R10", "reset mid-run", {hs_o, de_o, pix_ce}, 0);
    @(posedge clk); #1 rst = 1'b0;
    repeat (200) @(posedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule